// File: doc/BRIEF.md
# Sticky Peak Level Meter

This block watches a stereo stream of signed 20-bit converter samples and keeps, for each channel, a coarse 3-bit indication of the loudest sample seen. Each sample arrives with a valid strobe and a channel tag. The block takes the sample's magnitude and compares it against six fixed thresholds. The thresholds sit 1 dB apart in the top 6 dB below full scale, and a seventh test detects a full-scale sample.

Each channel's code only moves upward. It holds the maximum until a clear pulse arrives. That pulse is raised when status software reads the meter. A clear returns both channels to zero. A sample presented in the same cycle as the clear becomes the first value recorded after it. The result is registered, so a sample's effect is visible one clock edge after it is presented.

Top module: `peak_meter_top`

## Requirements
- R1: A sample tagged for one channel never changes the other channel's code. Tag 0 is the left channel and tag 1 is the right channel. Channel c is reported on `level_o[3c+2:3c]`.
- R2: A sample whose magnitude is below 262766 yields code 0, which means below -6 dB.
- R3: The threshold T(n) is the nearest integer to 524287·10^(-n/20), for n = 1..6. These are 467271, 416456, 371167, 330803, 294828 and 262766. A magnitude in the range T(7-k) ≤ mag < T(6-k) yields code k for k = 1..5. A magnitude from T(1) up to 524286 yields code 6.
- R4: A sample of magnitude 524287 yields code 7, which means clipping.
- R5: Without a clear, a channel's code becomes the larger of its current code and the new sample's code. It never decreases.
- R6: A clear pulse with no sample sets both channel codes to 0 at the next clock edge.
- R7: Magnitude is the absolute value of the two's-complement sample. The code -524288 saturates to 524287, and so reads as clipping.
- R8: When a clear and a sample arrive in the same cycle, the sampled channel takes that sample's own code and the other channel reads 0.
- R9: Reset sets both codes to 0. Every update appears one clock edge after the inputs that cause it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe |
| ch_i | input | CH_W (1) | Channel tag of the sample |
| sample_i | input | SAMPLE_W (20) | Signed two's-complement sample |
| clr_i | input | 1 | Clear pulse raised on a status read |
| level_o | output | NUM_CH*3 (6) | Per-channel sticky level codes |

## Verification
Every result is due exactly one clock edge after the inputs that produce it. This applies to a sample's code, a clear, and a clear combined with a sample. The bench drives each stimulus on a falling edge, releases it on the next falling edge, and compares both channel codes right there. Each sample is therefore checked after the single rising edge that registers it and before any further stimulus. The stimulus sweeps magnitudes two steps either side of every threshold, in both signs, with and without a combined clear. It also strides across the full signed range and runs a non-monotonic sequence that exercises stickiness.

// File: rtl/pm_pkg.sv
package pm_pkg;

    localparam int CODE_W    = 3;
    localparam int NUM_STEPS = 6;
    localparam logic [CODE_W-1:0] CODE_CLIP = 3'd7;

    // Threshold n dB below full scale for a 20-bit sample, rescaled to the
    // full-scale value of a sample of width sample_w.
    function automatic logic [63:0] step_threshold(input int n, input int sample_w);
        logic [63:0] base;
        logic [63:0] full;
        case (n)
            1:       base = 64'd467271;
            2:       base = 64'd416456;
            3:       base = 64'd371167;
            4:       base = 64'd330803;
            5:       base = 64'd294828;
            default: base = 64'd262766;
        endcase
        full = (64'd1 << (sample_w - 1)) - 64'd1;
        return (base * full) / 64'd524287;
    endfunction

endpackage

// File: rtl/pm_magnitude.sv
module pm_magnitude #(
    parameter int SAMPLE_W = 20,
    parameter int MAG_W    = SAMPLE_W - 1
) (
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic [MAG_W-1:0]    mag_o
);

    logic [MAG_W-1:0] mag_d;

    always_comb begin
        if (!sample_i[SAMPLE_W-1]) begin
            mag_d = sample_i[MAG_W-1:0];
        end else if (sample_i[MAG_W-1:0] == '0) begin
            // most negative code: saturate to the positive maximum
            mag_d = '1;
        end else begin
            mag_d = ~sample_i[MAG_W-1:0] + MAG_W'(1);
        end
    end

    assign mag_o = mag_d;

endmodule

// File: rtl/pm_quantizer.sv
module pm_quantizer
    import pm_pkg::*;
#(
    parameter int SAMPLE_W = 20,
    parameter int MAG_W    = SAMPLE_W - 1
) (
    input  logic [MAG_W-1:0]  mag_i,
    output logic [CODE_W-1:0] code_o
);

    logic [NUM_STEPS-1:0] above_d;
    logic                 clip_d;
    logic [CODE_W-1:0]    code_d;

    for (genvar n = 0; n < NUM_STEPS; n++) begin : g_step
        localparam logic [MAG_W-1:0] THR = MAG_W'(step_threshold(n + 1, SAMPLE_W));
        assign above_d[n] = (mag_i >= THR);
    end

    assign clip_d = (mag_i == {MAG_W{1'b1}});

    always_comb begin
        code_d = '0;
        for (int n = 0; n < NUM_STEPS; n++) begin
            code_d = code_d + CODE_W'(above_d[n]);
        end
        if (clip_d) begin
            code_d = CODE_CLIP;
        end
    end

    assign code_o = code_d;

endmodule

// File: rtl/pm_hold.sv
module pm_hold
    import pm_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CH_W   = 1
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     valid_i,
    input  logic [CH_W-1:0]          ch_i,
    input  logic [CODE_W-1:0]        code_i,
    input  logic                     clr_i,
    output logic [NUM_CH*CODE_W-1:0] level_o
);

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        code_t [NUM_CH-1:0] lvl;
    } hold_s;

    hold_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.lvl = '0;
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (valid_i && ch_i == CH_W'(c)) begin
                if (clr_i || code_i > st_q.lvl[c]) begin
                    st_d.lvl[c] = code_i;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.lvl;

endmodule

// File: rtl/peak_meter_top.sv
module peak_meter_top
    import pm_pkg::*;
#(
    parameter int SAMPLE_W = 20,
    parameter int NUM_CH   = 2,
    parameter int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     valid_i,
    input  logic [CH_W-1:0]          ch_i,
    input  logic [SAMPLE_W-1:0]      sample_i,
    input  logic                     clr_i,
    output logic [NUM_CH*CODE_W-1:0] level_o
);

    localparam int MAG_W = SAMPLE_W - 1;

    logic [MAG_W-1:0]  mag;
    logic [CODE_W-1:0] code;

    pm_magnitude #(
        .SAMPLE_W (SAMPLE_W),
        .MAG_W    (MAG_W)
    ) mag_i (
        .sample_i (sample_i),
        .mag_o    (mag)
    );

    pm_quantizer #(
        .SAMPLE_W (SAMPLE_W),
        .MAG_W    (MAG_W)
    ) quant_i (
        .mag_i  (mag),
        .code_o (code)
    );

    pm_hold #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) hold_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .valid_i (valid_i),
        .ch_i    (ch_i),
        .code_i  (code),
        .clr_i   (clr_i),
        .level_o (level_o)
    );

endmodule

// File: rtl/pm_checker.sv
module pm_checker
    import pm_pkg::*;
#(
    parameter int SAMPLE_W = 20,
    parameter int NUM_CH   = 2,
    parameter int CH_W     = 1
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic                     valid_i,
    input logic [CH_W-1:0]          ch_i,
    input logic [SAMPLE_W-1:0]      sample_i,
    input logic                     clr_i,
    input logic [NUM_CH*CODE_W-1:0] level_o
);

    localparam logic [SAMPLE_W-1:0] S_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};
    localparam logic [SAMPLE_W-1:0] S_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};
    localparam logic signed [SAMPLE_W-1:0] T_LOW = SAMPLE_W'(step_threshold(NUM_STEPS, SAMPLE_W));

    // R9: codes are zero whenever reset is held at a clock edge
    always @(posedge clk_i) begin
        if (!rst_ni) begin
            a_r9_reset_zero: assert (level_o == '0);
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        a_r5_never_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !clr_i |=> level_o[c*CODE_W +: CODE_W] >= $past(level_o[c*CODE_W +: CODE_W]));

        a_r1_other_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (valid_i && !clr_i && ch_i != CH_W'(c)) |=> $stable(level_o[c*CODE_W +: CODE_W]));

        a_r6_clear_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_i && !(valid_i && ch_i == CH_W'(c))) |=> level_o[c*CODE_W +: CODE_W] == '0);

        a_r4_full_scale_clip: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (valid_i && ch_i == CH_W'(c) && sample_i == S_MAX) |=> level_o[c*CODE_W +: CODE_W] == CODE_CLIP);

        a_r7_most_negative_clip: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (valid_i && ch_i == CH_W'(c) && sample_i == S_MIN) |=> level_o[c*CODE_W +: CODE_W] == CODE_CLIP);

        a_r8_clear_small_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (valid_i && clr_i && ch_i == CH_W'(c) && $signed(sample_i) < T_LOW && $signed(sample_i) > -T_LOW)
            |=> level_o[c*CODE_W +: CODE_W] == '0);
    end

endmodule

bind peak_meter_top pm_checker #(
    .SAMPLE_W (SAMPLE_W),
    .NUM_CH   (NUM_CH),
    .CH_W     (CH_W)
) chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .ch_i     (ch_i),
    .sample_i (sample_i),
    .clr_i    (clr_i),
    .level_o  (level_o)
);

// File: tb/peak_meter_top_tb.sv
module peak_meter_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int FULL       = 524287;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [0:0]  ch = '0;
    logic [19:0] sample = '0;
    logic        clr = 1'b0;
    logic [5:0]  level;

    int total = 0;
    int bad = 0;
    int exp_lvl [2];
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    peak_meter_top dut_i (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .valid_i  (valid),
        .ch_i     (ch),
        .sample_i (sample),
        .clr_i    (clr),
        .level_o  (level)
    );

    function automatic int thr(int n);
        return $rtoi(FULL * (10.0 ** (-n / 20.0)) + 0.5);
    endfunction

    // expected code from R2, R3, R4, R7
    function automatic int code_of(int s);
        int mag;
        int k;
        mag = (s < 0) ? ((s == -FULL - 1) ? FULL : -s) : s;
        if (mag == FULL) return 7;
        k = 0;
        for (int n = 1; n <= 6; n++) if (mag >= thr(n)) k++;
        return k;
    endfunction

    task automatic check(int ch_n, int got, int exp, string req);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s ch%0d got %0d expected %0d", req, ch_n, got, exp);
        end
    endtask

    task automatic check_both(string req);
        check(0, int'(level[2:0]), exp_lvl[0], req);
        check(1, int'(level[5:3]), exp_lvl[1], req);
    endtask

    // one stimulus cycle, then compare after the registering edge (R9 latency)
    task automatic op(bit v, int c, int s, bit cl, string req);
        int k;
        @(negedge clk);
        valid = v; ch = c[0:0]; sample = s[19:0]; clr = cl;
        @(negedge clk);
        valid = 0; clr = 0;
        if (cl) begin exp_lvl[0] = 0; exp_lvl[1] = 0; end
        if (v) begin
            k = code_of(s);
            if (cl || k > exp_lvl[c]) exp_lvl[c] = k;
        end
        check_both(req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        exp_lvl[0] = 0; exp_lvl[1] = 0;
        repeat (3) @(negedge clk);
        check_both("R9");          // reset state
        rst_n = 1'b1;
        @(negedge clk);
        check_both("R9");

        // R2/R3 boundaries: both signs, pure clear or combined clear (R8)
        for (int mode = 0; mode < 2; mode++)
            for (int n = 1; n <= 6; n++)
                for (int d = -2; d <= 2; d++)
                    for (int sg = 0; sg < 2; sg++) begin
                        int s = sg ? -(thr(n) + d) : thr(n) + d;
                        if (mode == 0) begin
                            op(0, 0, 0, 1, "R6");
                            op(1, n % 2, s, 0, "R3");
                        end else begin
                            op(1, n % 2, s, 1, "R8");
                        end
                    end

        // R4 and R7: full-scale edges
        op(1, 0, FULL, 1, "R4");
        op(1, 1, FULL - 1, 1, "R3");
        op(1, 1, -FULL - 1, 1, "R7");
        op(1, 0, -FULL, 1, "R7");
        op(1, 0, -(FULL - 1), 1, "R7");
        op(1, 0, 0, 1, "R2");
        op(1, 1, -1, 1, "R2");

        // R5 stickiness with R1 independence
        op(0, 0, 0, 1, "R6");
        op(1, 0, 100, 0, "R5");
        op(1, 0, 300000, 0, "R5");
        op(1, 0, 200, 0, "R5");
        op(1, 0, -420000, 0, "R5");
        op(1, 0, 5, 0, "R5");
        op(1, 1, -270000, 0, "R1");
        op(1, 1, 10, 0, "R1");
        op(1, 0, FULL, 0, "R5");
        op(1, 0, -3, 0, "R5");
        op(1, 1, 380000, 0, "R1");

        // R8: clear with sample on one channel zeroes the other
        op(1, 1, 1000, 1, "R8");
        op(1, 0, 470000, 0, "R5");
        op(1, 0, 12, 1, "R8");
        op(0, 1, FULL, 1, "R6");   // sample input ignored when not valid

        // stride over the whole signed range, combined clear
        for (int v = -FULL - 1; v <= FULL; v += 4093)
            op(1, (v >>> 12) & 1, v, 1, "R3");

        // stride without clears: running maximum per channel
        op(0, 0, 0, 1, "R6");
        for (int v = FULL; v >= -FULL - 1; v -= 9973)
            op(1, (v >>> 11) & 1, v / 2 + v / 4, 0, "R5");

        finish_run();
    end

endmodule